// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides, for each received CAN frame identifier, whether the frame is kept. It also reports which filter matched and which of two receive FIFOs the frame is routed to. It holds `NBANK` filter banks. Each bank has two 32-bit configuration words and four control flags: a width flag, a kind flag, an enable flag and a FIFO-route flag.

From its width and kind flags, a bank reads its two words in one of four ways:
- one 32-bit identifier/mask filter;
- two 32-bit exact identifiers;
- two 16-bit identifier/mask pairs;
- four 16-bit exact identifiers.

A frame descriptor arrives with a one-cycle `frm_valid` strobe. The block has no back-pressure: it takes a descriptor on any cycle, and the result appears as a one-cycle `res_valid` pulse exactly one clock later. The consumer must take it in that cycle.

Configuration goes through a plain write port. The enable flag can be written at any time. The words and the other flags of a bank change only while that bank is disabled. The intended sequence is: disable the bank, rewrite it, enable it again.

Top module: `can_id_filter`

## Requirements
- R1: After reset every bank is disabled with zero words and zero flags. A frame presented then gets `res_valid` with `res_accept` low, and all result outputs are zero during reset.
- R2: `res_valid` is high in exactly the cycles that follow a cycle with `frm_valid` high. The decision uses the configuration as it stood before that clock edge.
- R3: The frame is compared as a 32-bit word. For a standard frame this is {std_id[10:0], 18'b0, IDE, RTR, 1'b0}; for an extended frame it is {id[28:18], id[17:0], IDE, RTR, 1'b0}. In 32-bit mask form (flags width=1, kind=0), the frame passes when it agrees with word 1 on every bit that is set in word 2. This counts as filter 0 of the bank.
- R4: In 32-bit list form (width=1, kind=1), the frame passes when it equals word 1 (filter 0) or word 2 (filter 1).
- R5: The frame is compared as a 16-bit field {std_id[10:0], RTR, IDE, ext_id[17:15]}. In 16-bit mask form (width=0, kind=0), pair 0 uses ID word1[31:16] with mask word1[15:0], and pair 1 uses word2[31:16] with word2[15:0].
- R6: In 16-bit list form (width=0, kind=1), the frame passes when its field equals one of four halfwords: word1[31:16] (filter 0), word1[15:0] (filter 1), word2[31:16] (filter 2) or word2[15:0] (filter 3).
- R7: A disabled bank never matches, whatever its words hold.
- R8: Write port select `cfg_sel` is decoded as follows: 0 is word 1, 1 is word 2, 2 is the flags {route, kind, width} in `cfg_wdata[2:0]`, and 3 is enable in `cfg_wdata[0]`. Writes with select 0, 1 or 2 to an enabled bank are dropped.
- R9: When several enabled banks match, the lowest-numbered one is reported on `res_bank`.
- R10: `res_filt` is the matching filter's position within its bank plus the filter count (1, 2, 2 or 4 by form) of every lower-numbered bank, enabled or not.
- R11: `res_fifo` is the route flag of the reporting bank. When a result is not an accept, `res_bank`, `res_filt` and `res_fifo` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 word 1, 1 word 2, 2 flags, 3 enable |
| cfg_bank | input | BANK_W (5) | Bank written; values at or above NBANK are ignored |
| cfg_wdata | input | 32 | Write data |
| frm_valid | input | 1 | Frame descriptor strobe |
| frm_id | input | 29 | Identifier; a standard frame uses bits [10:0] |
| frm_ide | input | 1 | Extended-identifier flag |
| frm_rtr | input | 1 | Remote-request flag |
| res_valid | output | 1 | Decision strobe, one cycle after `frm_valid` |
| res_accept | output | 1 | Frame accepted |
| res_bank | output | BANK_W (5) | Matching bank |
| res_filt | output | FILT_W (7) | Matching filter, counted across banks |
| res_fifo | output | 1 | Target FIFO |

## Verification
The assertions take for granted that, after reset, the inputs carry known values on every clock edge. The write-protection property only looks at writes whose bank number is in range. The bench drives all inputs on the falling edge, so descriptors and writes are stable across each rising edge. It aims random writes only at banks 6 to 9 and sends random identifiers alongside a fixed set that hits each filter form. A behavioural model in the bench tracks the enable and write-protection rules, so the overlap of a write and a frame in the same cycle is checked as well.

// File: rtl/canf_pkg.sv
package canf_pkg;

  typedef enum logic [1:0] {
    SEL_WORD1 = 2'd0,
    SEL_WORD2 = 2'd1,
    SEL_FLAGS = 2'd2,
    SEL_ENBL  = 2'd3
  } cfg_sel_e;

  // flag vector layout {route, kind, width}
  localparam int FLAG_WIDTH = 0;
  localparam int FLAG_KIND  = 1;
  localparam int FLAG_ROUTE = 2;

  function automatic logic [31:0] frame_word32(logic [28:0] id, logic ide, logic rtr);
    logic [10:0] st;
    logic [17:0] ex;
    st = ide ? id[28:18] : id[10:0];
    ex = ide ? id[17:0] : 18'd0;
    return {st, ex, ide, rtr, 1'b0};
  endfunction

  function automatic logic [15:0] frame_word16(logic [28:0] id, logic ide, logic rtr);
    logic [10:0] st;
    logic [2:0]  ex;
    st = ide ? id[28:18] : id[10:0];
    ex = ide ? id[17:15] : 3'd0;
    return {st, rtr, ide, ex};
  endfunction

  function automatic logic [2:0] filters_in_bank(logic [2:0] flags);
    case ({flags[FLAG_WIDTH], flags[FLAG_KIND]})
      2'b10:   return 3'd1;
      2'b11:   return 3'd2;
      2'b00:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/canf_bank_regs.sv
module canf_bank_regs
  import canf_pkg::*;
#(
  parameter int NBANK  = 28,
  parameter int BANK_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_sel,
  input  logic [BANK_W-1:0]        cfg_bank,
  input  logic [31:0]              cfg_wdata,
  output logic [NBANK-1:0][31:0]   word1,
  output logic [NBANK-1:0][31:0]   word2,
  output logic [NBANK-1:0][2:0]    flags,
  output logic [NBANK-1:0]         enbl
);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit_bank;
    logic locked;
    assign hit_bank = cfg_we && (cfg_bank == BANK_W'(b));
    assign locked   = enbl[b];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word1[b] <= '0;
        word2[b] <= '0;
        flags[b] <= '0;
        enbl[b]  <= 1'b0;
      end else if (hit_bank) begin
        case (cfg_sel_e'(cfg_sel))
          SEL_WORD1: if (!locked) word1[b] <= cfg_wdata;
          SEL_WORD2: if (!locked) word2[b] <= cfg_wdata;
          SEL_FLAGS: if (!locked) flags[b] <= cfg_wdata[2:0];
          default:   enbl[b] <= cfg_wdata[0];
        endcase
      end
    end
  end

endmodule

// File: rtl/canf_bank_match.sv
module canf_bank_match
  import canf_pkg::*;
(
  input  logic [31:0] word1,
  input  logic [31:0] word2,
  input  logic [2:0]  flags,
  input  logic [31:0] fw32,
  input  logic [15:0] fw16,
  output logic        hit,
  output logic [1:0]  lidx
);

  logic [3:0] h;
  logic       m32, e1, e2, pa, pb;

  assign m32 = ((fw32 ^ word1) & word2) == 32'd0;
  assign e1  = fw32 == word1;
  assign e2  = fw32 == word2;
  assign pa  = ((fw16 ^ word1[31:16]) & word1[15:0]) == 16'd0;
  assign pb  = ((fw16 ^ word2[31:16]) & word2[15:0]) == 16'd0;

  always_comb begin
    case ({flags[FLAG_WIDTH], flags[FLAG_KIND]})
      2'b10:   h = {3'b000, m32};
      2'b11:   h = {2'b00, e2, e1};
      2'b00:   h = {2'b00, pb, pa};
      default: h = {fw16 == word2[15:0], fw16 == word2[31:16],
                    fw16 == word1[15:0], fw16 == word1[31:16]};
    endcase
  end

  always_comb begin
    hit = |h;
    if (h[0])      lidx = 2'd0;
    else if (h[1]) lidx = 2'd1;
    else if (h[2]) lidx = 2'd2;
    else           lidx = 2'd3;
  end

endmodule

// File: rtl/canf_prio_sel.sv
module canf_prio_sel
  import canf_pkg::*;
#(
  parameter int NBANK  = 28,
  parameter int BANK_W = 5,
  parameter int FILT_W = 7
) (
  input  logic [NBANK-1:0]        hit,
  input  logic [NBANK-1:0]        enbl,
  input  logic [NBANK-1:0][1:0]   lidx,
  input  logic [NBANK-1:0][2:0]   flags,
  output logic                    found,
  output logic [BANK_W-1:0]       bank,
  output logic [FILT_W-1:0]       filt,
  output logic                    fifo
);

  logic [FILT_W-1:0] base;

  always_comb begin
    found = 1'b0;
    bank  = '0;
    filt  = '0;
    fifo  = 1'b0;
    base  = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (!found && enbl[i] && hit[i]) begin
        found = 1'b1;
        bank  = BANK_W'(i);
        filt  = base + FILT_W'(lidx[i]);
        fifo  = flags[i][FLAG_ROUTE];
      end
      base = base + FILT_W'(filters_in_bank(flags[i]));
    end
  end

endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import canf_pkg::*;
#(
  parameter int NBANK = 28,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int FILT_W = $clog2(4 * NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [31:0]       cfg_wdata,
  input  logic              frm_valid,
  input  logic [28:0]       frm_id,
  input  logic              frm_ide,
  input  logic              frm_rtr,
  output logic              res_valid,
  output logic              res_accept,
  output logic [BANK_W-1:0] res_bank,
  output logic [FILT_W-1:0] res_filt,
  output logic              res_fifo
);

  logic [NBANK-1:0][31:0] w1_a, w2_a;
  logic [NBANK-1:0][2:0]  attr_a;
  logic [NBANK-1:0]       act_v;
  logic [NBANK-1:0]       hit_v;
  logic [NBANK-1:0][1:0]  lidx_v;
  logic [31:0]            fw32;
  logic [15:0]            fw16;
  logic                   sel_found, sel_fifo;
  logic [BANK_W-1:0]      sel_bank;
  logic [FILT_W-1:0]      sel_filt;

  assign fw32 = frame_word32(frm_id, frm_ide, frm_rtr);
  assign fw16 = frame_word16(frm_id, frm_ide, frm_rtr);

  canf_bank_regs #(.NBANK(NBANK), .BANK_W(BANK_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_bank  (cfg_bank),
    .cfg_wdata (cfg_wdata),
    .word1     (w1_a),
    .word2     (w2_a),
    .flags     (attr_a),
    .enbl      (act_v)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_match
    canf_bank_match u_match (
      .word1 (w1_a[b]),
      .word2 (w2_a[b]),
      .flags (attr_a[b]),
      .fw32  (fw32),
      .fw16  (fw16),
      .hit   (hit_v[b]),
      .lidx  (lidx_v[b])
    );
  end

  canf_prio_sel #(.NBANK(NBANK), .BANK_W(BANK_W), .FILT_W(FILT_W)) u_sel (
    .hit   (hit_v),
    .enbl  (act_v),
    .lidx  (lidx_v),
    .flags (attr_a),
    .found (sel_found),
    .bank  (sel_bank),
    .filt  (sel_filt),
    .fifo  (sel_fifo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_bank   <= '0;
      res_filt   <= '0;
      res_fifo   <= 1'b0;
    end else begin
      res_valid  <= frm_valid;
      res_accept <= frm_valid && sel_found;
      res_bank   <= frm_valid ? sel_bank : '0;
      res_filt   <= frm_valid ? sel_filt : '0;
      res_fifo   <= frm_valid && sel_fifo;
    end
  end

endmodule

// File: rtl/canf_checker.sv
module canf_checker #(
  parameter int NBANK  = 28,
  parameter int BANK_W = 5,
  parameter int FILT_W = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_we,
  input logic [1:0]             cfg_sel,
  input logic [BANK_W-1:0]      cfg_bank,
  input logic                   frm_valid,
  input logic                   res_valid,
  input logic                   res_accept,
  input logic [BANK_W-1:0]      res_bank,
  input logic [FILT_W-1:0]      res_filt,
  input logic                   res_fifo,
  input logic [NBANK-1:0]       act_v,
  input logic [NBANK-1:0][31:0] w1_a,
  input logic [NBANK-1:0][31:0] w2_a,
  input logic [NBANK-1:0][2:0]  attr_a
);

  logic [NBANK-1:0] act_d;
  logic             locked_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_d <= '0;
    else        act_d <= act_v;
  end

  assign locked_wr = cfg_we && (cfg_sel != 2'd3) && (int'(cfg_bank) < NBANK) &&
                     act_v[cfg_bank];

  // R2
  res_follows_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> res_valid);

  // R2
  no_spurious_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !res_valid);

  // R7
  accept_needs_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_accept) |-> act_d[res_bank]);

  // R8
  locked_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_wr |=> ($stable(w1_a) && $stable(w2_a) && $stable(attr_a)));

  // R11
  reject_fields_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_accept) |-> (res_bank == '0 && res_filt == '0 && !res_fifo));

  // R11
  accept_only_when_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> res_valid);

endmodule

bind can_id_filter canf_checker #(.NBANK(NBANK), .BANK_W(BANK_W), .FILT_W(FILT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_sel    (cfg_sel),
  .cfg_bank   (cfg_bank),
  .frm_valid  (frm_valid),
  .res_valid  (res_valid),
  .res_accept (res_accept),
  .res_bank   (res_bank),
  .res_filt   (res_filt),
  .res_fifo   (res_fifo),
  .act_v      (act_v),
  .w1_a       (w1_a),
  .w2_a       (w2_a),
  .attr_a     (attr_a)
);

// File: tb/can_id_filter_bench.sv
module can_id_filter_bench;

  localparam int NB = 28;
  localparam int BW = 5;
  localparam int FW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [BW-1:0] cfg_bank = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          frm_valid = 1'b0;
  logic [28:0]   frm_id = '0;
  logic          frm_ide = 1'b0;
  logic          frm_rtr = 1'b0;
  logic          res_valid, res_accept, res_fifo;
  logic [BW-1:0] res_bank;
  logic [FW-1:0] res_filt;

  int total = 0;
  int fails = 0;
  bit done  = 0;
  string cur_req = "R1";

  // behavioural model state
  logic [31:0] m_w1 [NB];
  logic [31:0] m_w2 [NB];
  bit          m_width [NB];
  bit          m_kind [NB];
  bit          m_route [NB];
  bit          m_en [NB];
  int e_v, e_acc, e_bank, e_filt, e_fifo;

  always #5 clk = ~clk;

  can_id_filter #(.NBANK(NB)) u_can_id_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_bank(cfg_bank),
    .cfg_wdata(cfg_wdata), .frm_valid(frm_valid), .frm_id(frm_id), .frm_ide(frm_ide),
    .frm_rtr(frm_rtr), .res_valid(res_valid), .res_accept(res_accept), .res_bank(res_bank),
    .res_filt(res_filt), .res_fifo(res_fifo));

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc32(logic [28:0] id, bit ide, bit rtr);
    if (ide) return {id, ide, rtr, 1'b0};
    return {id[10:0], 18'd0, ide, rtr, 1'b0};
  endfunction

  function automatic logic [15:0] enc16(logic [28:0] id, bit ide, bit rtr);
    if (ide) return {id[28:18], rtr, ide, id[17:15]};
    return {id[10:0], rtr, ide, 3'd0};
  endfunction

  task automatic model_eval();
    logic [31:0] f32;
    logic [15:0] f16;
    int base;
    bit fnd;
    e_v = int'(frm_valid); e_acc = 0; e_bank = 0; e_filt = 0; e_fifo = 0;
    if (frm_valid) begin
      f32 = enc32(frm_id, frm_ide, frm_rtr);
      f16 = enc16(frm_id, frm_ide, frm_rtr);
      base = 0; fnd = 0;
      for (int b = 0; b < NB; b++) begin
        int n;
        int hi;
        logic [15:0] hw [4];
        n = m_width[b] ? (m_kind[b] ? 2 : 1) : (m_kind[b] ? 4 : 2);
        hi = -1;
        hw[0] = m_w1[b][31:16]; hw[1] = m_w1[b][15:0];
        hw[2] = m_w2[b][31:16]; hw[3] = m_w2[b][15:0];
        if (m_en[b] && !fnd) begin
          if (m_width[b] && !m_kind[b]) begin
            if (((f32 ^ m_w1[b]) & m_w2[b]) == 0) hi = 0;
          end else if (m_width[b]) begin
            if (f32 == m_w1[b]) hi = 0;
            else if (f32 == m_w2[b]) hi = 1;
          end else if (!m_kind[b]) begin
            if (((f16 ^ hw[0]) & hw[1]) == 0) hi = 0;
            else if (((f16 ^ hw[2]) & hw[3]) == 0) hi = 1;
          end else begin
            for (int k = 3; k >= 0; k--) if (f16 == hw[k]) hi = k;
          end
          if (hi >= 0) begin
            fnd = 1; e_acc = 1; e_bank = b; e_filt = base + hi; e_fifo = int'(m_route[b]);
          end
        end
        base += n;
      end
    end
  endtask

  task automatic model_write();
    int b;
    b = int'(cfg_bank);
    if (cfg_we && b < NB) begin
      if (cfg_sel == 2'd3) m_en[b] = cfg_wdata[0];
      else if (!m_en[b]) begin
        if (cfg_sel == 2'd0) m_w1[b] = cfg_wdata;
        else if (cfg_sel == 2'd1) m_w2[b] = cfg_wdata;
        else begin
          m_width[b] = cfg_wdata[0]; m_kind[b] = cfg_wdata[1]; m_route[b] = cfg_wdata[2];
        end
      end
    end
  endtask

  // one clock: model predicts, edge, then compare away from the edge
  task automatic cyc();
    model_eval();
    @(posedge clk);
    model_write();
    @(negedge clk);
    chk(cur_req, "res_valid (R2)", int'(res_valid), e_v);
    chk(cur_req, "res_accept", int'(res_accept), e_acc);
    chk(cur_req, "res_bank", int'(res_bank), e_bank);
    chk(cur_req, "res_filt", int'(res_filt), e_filt);
    chk(cur_req, "res_fifo", int'(res_fifo), e_fifo);
  endtask

  task automatic wr(int bank, int sel, logic [31:0] data);
    cfg_we = 1'b1; cfg_bank = BW'(bank); cfg_sel = 2'(sel); cfg_wdata = data;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic send(logic [28:0] id, bit ide, bit rtr);
    frm_valid = 1'b1; frm_id = id; frm_ide = ide; frm_rtr = rtr;
    cyc();
    frm_valid = 1'b0;
  endtask

  task automatic expect_res(string req, int acc, int bank, int filt, int fifo);
    chk(req, "explicit valid", int'(res_valid), 1);
    chk(req, "explicit accept", int'(res_accept), acc);
    chk(req, "explicit bank", int'(res_bank), bank);
    chk(req, "explicit filt", int'(res_filt), filt);
    chk(req, "explicit fifo", int'(res_fifo), fifo);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_w1[b] = '0; m_w2[b] = '0; m_width[b] = 0; m_kind[b] = 0; m_route[b] = 0; m_en[b] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset
    chk("R1", "reset res_valid", int'(res_valid), 0);
    chk("R1", "reset res_accept", int'(res_accept), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    send(29'h321, 0, 0);
    expect_res("R1", 0, 0, 0, 0);

    // configuration: banks 0..3, flags {route, kind, width}
    cur_req = "R8";
    wr(0, 0, 32'h6420_0000); wr(0, 1, 32'hFFE0_0004); wr(0, 2, 32'h1);
    wr(1, 0, 32'h091A_2B3C); wr(1, 1, 32'hAAA0_0002); wr(1, 2, 32'h7);
    wr(2, 0, 32'hE000_E008); wr(2, 1, 32'h1560_FFF8); wr(2, 2, 32'h0);
    wr(3, 0, 32'h0200_0400); wr(3, 1, 32'h0600_0800); wr(3, 2, 32'h6);
    cur_req = "R7";
    send(29'h321, 0, 0);
    expect_res("R7", 0, 0, 0, 0);
    for (int b = 0; b < 4; b++) wr(b, 3, 32'h1);

    cur_req = "R3";
    send(29'h321, 0, 0); expect_res("R3", 1, 0, 0, 0);
    send(29'h322, 0, 0); expect_res("R3", 0, 0, 0, 0);
    send(29'h321 << 18, 1, 0); expect_res("R3", 0, 0, 0, 0);
    send(29'h321, 0, 1); expect_res("R3", 1, 0, 0, 0);

    cur_req = "R4";
    send(29'h1234567, 1, 0); expect_res("R4", 1, 1, 1, 1);
    send(29'h555, 0, 1); expect_res("R4", 1, 1, 2, 1);
    send(29'h555, 0, 0); expect_res("R4", 0, 0, 0, 0);

    cur_req = "R5";
    send(29'h7A5, 0, 0); expect_res("R5", 1, 2, 3, 0);
    send(29'h6FF, 0, 0); expect_res("R5", 0, 0, 0, 0);
    send(29'h0AB, 0, 0); expect_res("R5", 1, 2, 4, 0);
    send(29'h0AB, 0, 1); expect_res("R5", 0, 0, 0, 0);

    cur_req = "R6";
    send(29'h040, 0, 0); expect_res("R6", 1, 3, 8, 1);
    send(29'h020, 0, 0); expect_res("R6", 1, 3, 6, 1);
    send(29'h041, 0, 0); expect_res("R6", 0, 0, 0, 0);

    cur_req = "R8";
    wr(0, 0, 32'h6440_0000);
    wr(3, 2, 32'h1);
    send(29'h321, 0, 0); expect_res("R8", 1, 0, 0, 0);
    send(29'h322, 0, 0); expect_res("R8", 0, 0, 0, 0);
    send(29'h040, 0, 0); expect_res("R8", 1, 3, 8, 1);

    cur_req = "R7";
    wr(0, 3, 32'h0);
    send(29'h321, 0, 0); expect_res("R7", 0, 0, 0, 0);
    wr(0, 0, 32'h6440_0000);
    wr(0, 3, 32'h1);
    send(29'h322, 0, 0); expect_res("R8", 1, 0, 0, 0);

    cur_req = "R9";
    wr(5, 3, 32'h1);
    send(29'h7A5, 0, 0); expect_res("R9", 1, 2, 3, 0);
    send(29'h123, 0, 0); expect_res("R10", 1, 5, 11, 0);
    wr(2, 3, 32'h0);
    send(29'h7A5, 0, 0); expect_res("R9", 1, 5, 11, 0);
    wr(2, 3, 32'h1);

    cur_req = "R2";
    cyc();
    chk("R2", "idle res_valid", int'(res_valid), 0);
    send(29'h040, 0, 0);
    send(29'h1234567, 1, 0); expect_res("R11", 1, 1, 1, 1);

    cur_req = "R10";
    wr(5, 3, 32'h0);
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 2) begin
        cfg_we = 1'b1; cfg_bank = BW'($urandom_range(6, 9));
        cfg_sel = 2'($urandom_range(0, 3)); cfg_wdata = $urandom;
      end
      frm_valid = ($urandom_range(0, 3) != 0);
      case ($urandom_range(0, 5))
        0: begin frm_id = 29'h321; frm_ide = 0; end
        1: begin frm_id = 29'h1234567; frm_ide = 1; end
        2: begin frm_id = 29'(32'h700 + $urandom_range(0, 255)); frm_ide = 0; end
        3: begin frm_id = 29'(32'h10 * $urandom_range(1, 4)); frm_ide = 0; end
        default: begin frm_id = 29'($urandom); frm_ide = 1'($urandom); end
      endcase
      frm_rtr = 1'($urandom);
      cyc();
      cfg_we = 1'b0;
    end
    frm_valid = 1'b0;
    cyc();
    finish_run();
  end

endmodule